// File: doc/BRIEF.md
# Dual 16-bit Pattern Multiply-Accumulate Unit

This execution unit carries out one instruction of a SIMD extension. It has a private file of sixteen 32-bit registers. It takes a 32-bit instruction word over a valid/ready handshake and reads two source registers, B and C, from that word. Each source is split into two signed 16-bit halves. The unit forms two products from those halves. A 2-bit operand field picks which halves go into each product. Each product is then added to or subtracted from its own accumulator register: the left product goes to A and the right product goes to D. A second 2-bit field chooses add or subtract for each of the two. The new A and D values are written back one clock after the instruction is accepted.

A control bit gates every write the instruction makes. When the bit is clear, the instruction still completes but changes nothing. A host port reads and writes the register file directly and also sets the control bit.

Back-pressure works as follows. `instr_ready` is high whenever no writeback is pending. An instruction is accepted on a rising edge where `instr_valid` and `instr_ready` are both high. In the next cycle `instr_ready` is low, so an instruction held valid through that cycle is not taken. The source must keep `instr_word` stable until it is accepted. The unit therefore accepts at most one instruction every two cycles.

Top module: `dmac16_unit`

## Requirements
- R1: Register indices come from the instruction word: A is bits [9:6], B is bits [13:10], C is bits [17:14] and D is bits [21:18]. The operand field is bits [23:22] and the accumulate field is bits [25:24]. All other bits are ignored.
- R2: Each source is split into a low half (bits 15:0) and a high half (bits 31:16). Both halves are treated as signed two's-complement values.
- R3: The operand field selects the products, given as (left, right). 0 gives (B.hi×C.hi, B.lo×C.lo). 1 gives (B.lo×C.hi, B.lo×C.lo). 2 gives (B.hi×C.hi, B.hi×C.lo). 3 gives (B.lo×C.hi, B.hi×C.lo).
- R4: The accumulate field sets the operation for each product. 0 gives A+left and D+right. 1 gives A+left and D−right. 2 gives A−left and D+right. 3 gives A−left and D−right.
- R5: All sums and differences wrap modulo 2^32. There is no saturation.
- R6: If the control bit is clear when an instruction is accepted, that instruction writes no register. It still produces its `done` pulse.
- R7: Both old values are read at acceptance. When A and D name the same register, the D result is the one kept.
- R8: Register 0 always reads zero. Writes to it from the host port or from a writeback are discarded.
- R9: The results are written on the clock edge that follows acceptance. `done` is high for exactly that one cycle.
- R10: A synchronous active-high reset clears every register and the control bit. After reset, `done` is low and `instr_ready` is high.
- R11: The host port writes a register on a clock edge where `host_we` is high, and `host_rdata` shows register `host_ridx` combinationally. If a host write and a writeback target the same register in the same cycle, the writeback value is kept.
- R12: While `instr_ready` is low, `instr_valid` is not accepted. An instruction held valid across that cycle executes exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is offered |
| instr_ready | output | 1 | Unit can accept an instruction this cycle |
| instr_word | input | 32 | Instruction with register indices and pattern fields |
| done | output | 1 | Writeback cycle of an accepted instruction |
| ctl_we | input | 1 | Load the control bit |
| ctl_enable | input | 1 | New value of the control bit |
| host_we | input | 1 | Host register write strobe |
| host_widx | input | 4 | Host write index |
| host_wdata | input | 32 | Host write data |
| host_ridx | input | 4 | Host read index |
| host_rdata | output | 32 | Host read data |

## Verification
Two functions can land on the same register in the same cycle. The first case is a host-port write that arrives in the writeback cycle of an accepted instruction. The bench provokes it by writing to A's index in the cycle after acceptance, and judges it correct when the accumulated value, not the host value, reads back afterwards. The second case is an instruction whose A and D indices are equal, so both results aim at one register on the same edge. There the D result must be the survivor. A behavioural model running alongside the design checks every cycle for both cases, including during a long random tail that mixes host writes with instructions.

// File: rtl/dmac16_pkg.sv
package dmac16_pkg;
  localparam int unsigned IW_A_LSB   = 6;
  localparam int unsigned IW_B_LSB   = 10;
  localparam int unsigned IW_C_LSB   = 14;
  localparam int unsigned IW_D_LSB   = 18;
  localparam int unsigned IW_OPS_LSB = 22;
  localparam int unsigned IW_ACC_LSB = 24;

  typedef enum logic [1:0] {
    OPS_HH_LL = 2'd0,
    OPS_LH_LL = 2'd1,
    OPS_HH_HL = 2'd2,
    OPS_LH_HL = 2'd3
  } opsel_e;

  typedef enum logic [1:0] {
    ACC_ADD_ADD = 2'd0,
    ACC_ADD_SUB = 2'd1,
    ACC_SUB_ADD = 2'd2,
    ACC_SUB_SUB = 2'd3
  } accsel_e;

  typedef struct packed {
    logic [3:0] ia;
    logic [3:0] ib;
    logic [3:0] ic;
    logic [3:0] id;
    opsel_e     ops;
    accsel_e    acc;
  } dmac_fields_t;
endpackage

// File: rtl/dmac16_decode.sv
module dmac16_decode
  import dmac16_pkg::*;
(
  input  logic [31:0]  word,
  output dmac_fields_t fields
);
  always_comb begin
    fields.ia  = word[IW_A_LSB +: 4];
    fields.ib  = word[IW_B_LSB +: 4];
    fields.ic  = word[IW_C_LSB +: 4];
    fields.id  = word[IW_D_LSB +: 4];
    fields.ops = opsel_e'(word[IW_OPS_LSB +: 2]);
    fields.acc = accsel_e'(word[IW_ACC_LSB +: 2]);
  end
endmodule

// File: rtl/dmac16_regfile.sv
module dmac16_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned NRD    = 5,
  parameter int unsigned NWR    = 3,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ridx  [NRD],
  output logic [DATA_W-1:0] rdata [NRD],
  input  logic              we    [NWR],
  input  logic [IDX_W-1:0]  widx  [NWR],
  input  logic [DATA_W-1:0] wdata [NWR]
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Later write ports take priority: their assignment is the last one on the edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int p = 0; p < NWR; p++) begin
        if (we[p] && (widx[p] != '0)) mem[widx[p]] <= wdata[p];
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = (ridx[r] == '0) ? '0 : mem[ridx[r]];
  end

  // R8: the storage cell for register 0 is never written
  p_zero_cell_r8: assert property (@(posedge clk) disable iff (rst) mem[0] == '0)
    else $error("register 0 storage changed");
endmodule

// File: rtl/dmac16_lane.sv
module dmac16_lane #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic [HALF_W-1:0] x,
  input  logic [HALF_W-1:0] y,
  input  logic [DATA_W-1:0] acc_old,
  input  logic              sub,
  output logic [DATA_W-1:0] acc_new
);
  logic signed [HALF_W-1:0] xs, ys;
  logic signed [DATA_W-1:0] prod;

  always_comb begin
    xs      = x;
    ys      = y;
    prod    = xs * ys;
    acc_new = sub ? (acc_old - prod) : (acc_old + prod);
  end
endmodule

// File: rtl/dmac16_unit.sv
module dmac16_unit
  import dmac16_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [31:0]       instr_word,
  output logic              done,
  input  logic              ctl_we,
  input  logic              ctl_enable,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_widx,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [IDX_W-1:0]  host_ridx,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int unsigned NRD = 5;
  localparam int unsigned NWR = 3;

  dmac_fields_t f;
  logic              en_q;
  logic              stg_vld, stg_we;
  logic [IDX_W-1:0]  stg_ia, stg_id;
  logic [DATA_W-1:0] stg_a, stg_d;
  logic              accept;

  logic [IDX_W-1:0]  ridx  [NRD];
  logic [DATA_W-1:0] rdata [NRD];
  logic              we    [NWR];
  logic [IDX_W-1:0]  widx  [NWR];
  logic [DATA_W-1:0] wdata [NWR];

  logic [HALF_W-1:0] lx [2];
  logic [HALF_W-1:0] ly [2];
  logic [DATA_W-1:0] lold [2];
  logic [DATA_W-1:0] lnew [2];
  logic              lsub [2];

  dmac16_decode u_dec (.word(instr_word), .fields(f));

  // read ports: 0=A 1=B 2=C 3=D 4=host
  assign ridx[0] = f.ia;
  assign ridx[1] = f.ib;
  assign ridx[2] = f.ic;
  assign ridx[3] = f.id;
  assign ridx[4] = host_ridx;
  assign host_rdata = rdata[4];

  // write ports in rising priority: host, A, D
  assign we[0]    = host_we;
  assign widx[0]  = host_widx;
  assign wdata[0] = host_wdata;
  assign we[1]    = stg_vld && stg_we;
  assign widx[1]  = stg_ia;
  assign wdata[1] = stg_a;
  assign we[2]    = stg_vld && stg_we;
  assign widx[2]  = stg_id;
  assign wdata[2] = stg_d;

  dmac16_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NRD(NRD), .NWR(NWR)) u_rf (
    .clk(clk), .rst(rst), .ridx(ridx), .rdata(rdata),
    .we(we), .widx(widx), .wdata(wdata)
  );

  // Operand routing. Lane 0 is the left product (to A), lane 1 the right product (to D).
  // Bit 0 of the operand field moves the left B half to low; bit 1 moves the right B half to high.
  always_comb begin
    lx[0]   = f.ops[0] ? rdata[1][HALF_W-1:0] : rdata[1][DATA_W-1:HALF_W];
    ly[0]   = rdata[2][DATA_W-1:HALF_W];
    lx[1]   = f.ops[1] ? rdata[1][DATA_W-1:HALF_W] : rdata[1][HALF_W-1:0];
    ly[1]   = rdata[2][HALF_W-1:0];
    lold[0] = rdata[0];
    lold[1] = rdata[3];
    lsub[0] = f.acc[1];
    lsub[1] = f.acc[0];
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    dmac16_lane #(.DATA_W(DATA_W)) u_lane (
      .x(lx[l]), .y(ly[l]), .acc_old(lold[l]), .sub(lsub[l]), .acc_new(lnew[l])
    );
  end

  assign instr_ready = !stg_vld;
  assign accept      = instr_valid && instr_ready;
  assign done        = stg_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      stg_vld <= 1'b0;
      stg_we  <= 1'b0;
      stg_ia  <= '0;
      stg_id  <= '0;
      stg_a   <= '0;
      stg_d   <= '0;
    end else begin
      if (ctl_we) en_q <= ctl_enable;
      stg_vld <= accept;
      if (accept) begin
        stg_we <= en_q;
        stg_ia <= f.ia;
        stg_id <= f.id;
        stg_a  <= lnew[0];
        stg_d  <= lnew[1];
      end
    end
  end

  // R9: acceptance leads to done on the next edge
  p_done_next_r9: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_ready) |=> done)
    else $error("done missing after accept");

  // R12: a held request is not taken twice in a row
  p_single_done_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done on consecutive cycles");

  // R6: an instruction accepted while disabled drives no write port
  p_gated_write_r6: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_ready && !en_q) |=> !(we[1] || we[2]))
    else $error("write while disabled");

  // R10: the first cycle out of reset is idle and disabled
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !en_q))
    else $error("state not cleared by reset");
endmodule

// File: tb/dmac16_unit_tb.sv
module dmac16_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic        done;
  logic        ctl_we = 1'b0, ctl_enable = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_widx = '0, host_ridx = '0;
  logic [31:0] host_wdata = '0, host_rdata;

  always #4 clk = ~clk;

  dmac16_unit dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .done(done), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
    .host_we(host_we), .host_widx(host_widx), .host_wdata(host_wdata),
    .host_ridx(host_ridx), .host_rdata(host_rdata)
  );

  int    checks = 0, errors = 0, cyc = 0;
  string cur = "R10";

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_reg [16];
  bit          m_en, m_pend, m_pwe;
  int          m_pa, m_pd;
  logic [31:0] m_va, m_vd;

  function automatic logic [31:0] smul(logic [15:0] x, logic [15:0] y);
    int a, b;
    a = $signed(x);
    b = $signed(y);
    return a * b;
  endfunction

  always @(posedge clk) begin
    bit          acc_now;
    int          ia, ib, ic, id, ops, acs;
    logic [31:0] b, c, lp, rp, na, nd;
    logic [15:0] bl, bh, cl, ch;
    if (rst) begin
      for (int i = 0; i < 16; i++) m_reg[i] = '0;
      m_en = 0; m_pend = 0; m_pwe = 0;
    end else begin
      acc_now = instr_valid && !m_pend;
      if (acc_now) begin
        ia = instr_word[9:6];  ib = instr_word[13:10];
        ic = instr_word[17:14]; id = instr_word[21:18];
        ops = instr_word[23:22]; acs = instr_word[25:24];
        b = m_reg[ib]; c = m_reg[ic];
        bl = b[15:0]; bh = b[31:16]; cl = c[15:0]; ch = c[31:16];
        case (ops)
          0: begin lp = smul(bh, ch); rp = smul(bl, cl); end
          1: begin lp = smul(bl, ch); rp = smul(bl, cl); end
          2: begin lp = smul(bh, ch); rp = smul(bh, cl); end
          default: begin lp = smul(bl, ch); rp = smul(bh, cl); end
        endcase
        na = (acs >= 2) ? m_reg[ia] - lp : m_reg[ia] + lp;
        nd = (acs % 2 == 1) ? m_reg[id] - rp : m_reg[id] + rp;
      end
      if (host_we && host_widx != 0) m_reg[host_widx] = host_wdata;
      if (m_pend && m_pwe) begin
        if (m_pa != 0) m_reg[m_pa] = m_va;
        if (m_pd != 0) m_reg[m_pd] = m_vd;
      end
      if (acc_now) begin
        m_pwe = m_en; m_pa = ia; m_pd = id; m_va = na; m_vd = nd;
      end
      m_pend = acc_now;
      if (ctl_we) m_en = ctl_enable;
    end
  end

  // per-clock comparison, with a read index that scans the file unless pinned
  bit       pin = 0;
  int       pin_idx = 0;
  int       scan = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(done == m_pend, {cur, "/R9 done"}, 32'(done), 32'(m_pend));
      chk(instr_ready == !m_pend, {cur, "/R12 ready"}, 32'(instr_ready), 32'(!m_pend));
      chk(host_rdata == m_reg[host_ridx], {cur, "/R11 rdata"}, host_rdata, m_reg[host_ridx]);
    end
    scan = (scan + 1) % 16;
    host_ridx <= pin ? 4'(pin_idx) : 4'(scan);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus (all tasks start and end at a negedge) ----------------
  function automatic logic [31:0] enc(int a, int b, int c, int d, int o, int ac);
    return {6'd0, 2'(ac), 2'(o), 4'(d), 4'(c), 4'(b), 4'(a), 6'd0};
  endfunction

  task automatic issue(logic [31:0] w);
    instr_valid = 1'b1;
    instr_word  = w;
    while (!instr_ready) @(negedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic hwrite(int i, logic [31:0] v);
    host_we = 1'b1; host_widx = 4'(i); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_en(bit v);
    ctl_we = 1'b1; ctl_enable = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic rd_check(int i, logic [31:0] exp, string req);
    pin = 1; pin_idx = i;
    @(negedge clk);
    @(negedge clk);
    chk(host_rdata == exp, req, host_rdata, exp);
    pin = 0;
  endtask

  task automatic setup4();
    hwrite(1, 32'd100);
    hwrite(2, 32'h0003_FFFE);   // hi 3, lo -2
    hwrite(3, 32'h0005_0007);   // hi 5, lo 7
    hwrite(4, 32'd200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur = "R10";
    chk(instr_ready == 1'b1 && done == 1'b0, "R10 idle", {instr_ready, done}, 2'b10);
    rd_check(5, 32'd0, "R10 cleared");

    cur = "R11";
    setup4();
    rd_check(2, 32'h0003_FFFE, "R11 host write");

    cur = "R6";
    issue(enc(1, 2, 3, 4, 0, 0));
    @(negedge clk);
    rd_check(1, 32'd100, "R6 A untouched");
    rd_check(4, 32'd200, "R6 D untouched");

    set_en(1);
    cur = "R3";
    issue(enc(1, 2, 3, 4, 3, 0));           // left -2*5, right 3*7
    @(negedge clk);
    rd_check(1, 32'd90, "R3 pattern3 left R2");
    rd_check(4, 32'd221, "R3 pattern3 right");

    cur = "R4";
    setup4();
    issue(enc(1, 2, 3, 4, 0, 3));           // A-15, D-(-14)
    @(negedge clk);
    rd_check(1, 32'd85, "R4 sub left");
    rd_check(4, 32'd214, "R4 sub right");

    cur = "R1";
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 4; a++) begin
        setup4();
        issue({6'h2A, enc(1, 2, 3, 4, o, a)} | 32'hFC00_002A);  // junk in ignored bits
        @(negedge clk);
      end

    cur = "R5";
    hwrite(1, 32'h7FFF_FFFF);
    hwrite(5, 32'h7FFF_7FFF);
    issue(enc(1, 5, 5, 4, 0, 0));
    @(negedge clk);
    rd_check(1, 32'hBFFF_0000, "R5 wrap");

    cur = "R7";
    setup4();
    hwrite(5, 32'd1000);
    issue(enc(5, 2, 3, 5, 3, 0));
    @(negedge clk);
    rd_check(5, 32'd1021, "R7 D wins");

    cur = "R8";
    hwrite(6, 32'd50);
    hwrite(0, 32'hDEAD_BEEF);
    issue(enc(0, 2, 3, 6, 0, 0));
    @(negedge clk);
    rd_check(0, 32'd0, "R8 zero reg");
    rd_check(6, 32'd36, "R8 D beside zero A");

    cur = "R12";
    hwrite(7, 32'd0);
    hwrite(8, 32'd0);
    issue(enc(7, 2, 3, 8, 0, 0));
    issue(enc(7, 2, 3, 8, 0, 0));           // offered while ready is low
    @(negedge clk);
    rd_check(7, 32'd30, "R12 exactly twice");
    rd_check(8, 32'hFFFF_FFE4, "R12 right twice");

    cur = "R11";
    hwrite(9, 32'd0);
    instr_valid = 1'b1; instr_word = enc(9, 2, 3, 10, 0, 0);
    @(negedge clk);
    instr_valid = 1'b0;
    host_we = 1'b1; host_widx = 4'd9; host_wdata = 32'd777;   // writeback cycle
    @(negedge clk);
    host_we = 1'b0;
    rd_check(9, 32'd15, "R11 writeback beats host");

    cur = "R9";
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 6)
        0: hwrite($urandom % 16, $urandom);
        1: set_en(($urandom % 4) != 0);
        2: @(negedge clk);
        default: issue($urandom);
      endcase
    end
    repeat (4) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule